// File: doc/BRIEF.md
# Audio Interface Control Register File

This block is the software-visible control and interrupt front end of a stereo digital audio interface core. A simple 32-bit register port (address, write strobe, write data, read strobe, read data) reaches a control word that starts the core, asks for a FIFO flush and picks a clock configuration code. The same port reaches an interrupt enable mask, a global interrupt gate, a status register whose bits clear when a one is written to them, a soft-reset register that reacts only to a key value, and two read-only words taken straight from the receive path (channel status and user data).

The framing, line coding and FIFO logic sit outside this block. Here they appear only as plain signals. Event pulses come in and set status bits. Core enable, clock code, flush and soft-reset pulses go out. The enabled status bits are merged into one level interrupt.

Top module: `audio_ctrl_regs`

## Requirements
- R1: After reset, every stored register reads 0, and coreEn, clkCfg, fifoFlush, softRstOut and irqOut are all 0.
- R2: A write to offset 0x44 stores bit 0 as coreEn and bits 5:2 as the 4-bit clkCfg code. Both drive their outputs from the next cycle. A read of 0x44 returns them in the same positions, with every other bit 0.
- R3: A write to 0x44 with bit 1 set raises fifoFlush for exactly one cycle, in the cycle after the write. Bit 1 is not stored and always reads back 0.
- R4: The status register sits at 0x20 and holds one bit per event input (8 by default, upper bits read 0). A pulse on evtIn[i] sets bit i. evtIn[5] marks a newly received channel status word. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R5: If an event arrives on a bit in the same cycle that a write to 0x20 clears that bit, the bit stays set.
- R6: The interrupt enable mask at 0x28 stores the low 8 bits of a write. It reads back in the same bits, with the upper bits 0.
- R7: The global enable is bit 31 of offset 0x1C, and only that bit is stored. irqOut is high exactly when the global enable is set and some status bit is set together with its enable bit.
- R8: Writing exactly 0x0000000A to 0x40 raises softRstOut for one cycle. In the cycle after that pulse, the control fields, enable mask, status and global enable all read 0. Any other value written to 0x40 has no effect, and 0x40 reads 0.
- R9: Offset 0x4C reads chanStatusIn and offset 0x64 reads userDataIn. Writes to either offset change no state.
- R10: A read of any offset not listed above returns 0, including misaligned offsets.
- R11: regRdData is registered. It carries the addressed value in the cycle after regRdEn is high, and 0 in the cycle after regRdEn is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte offset of the access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 32 | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | 32 | Registered read data |
| evtIn | input | 8 | One-cycle event pulses that set status bits |
| chanStatusIn | input | 32 | Received channel status word |
| userDataIn | input | 32 | Received user data word |
| coreEn | output | 1 | Core run enable |
| clkCfg | output | 4 | Clock configuration code |
| fifoFlush | output | 1 | One-cycle FIFO flush pulse |
| softRstOut | output | 1 | One-cycle core reset pulse |
| irqOut | output | 1 | Level interrupt |

## Verification
The assertions expect each access cycle to carry either a write or a read, never both. They also expect no register write in the cycle where softRstOut is high, because the pending clear overrides that write. The stimulus drives every access for exactly one cycle and leaves an idle cycle after each key write. It raises evtIn only as single-cycle pulses, except in the one case that deliberately lines an event up with a clearing write. The read-only words are held constant, so a read of them can be compared against a fixed value.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;
  localparam int DATA_W = 32;
  localparam logic [7:0] OFS_GIE  = 8'h1C;
  localparam logic [7:0] OFS_STS  = 8'h20;
  localparam logic [7:0] OFS_IEN  = 8'h28;
  localparam logic [7:0] OFS_KEY  = 8'h40;
  localparam logic [7:0] OFS_CTRL = 8'h44;
  localparam logic [7:0] OFS_CHST = 8'h4C;
  localparam logic [7:0] OFS_USER = 8'h64;
  localparam logic [DATA_W-1:0] RESET_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    RD_NONE, RD_GIE, RD_STS, RD_IEN, RD_CTRL, RD_CHST, RD_USER
  } rdSel_e;

  // strobes from address decode to the register datapath
  typedef struct packed {
    logic   wrGie;
    logic   wrSts;
    logic   wrIen;
    logic   wrCtrl;
    logic   keyHit;
    logic   rdEn;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/audio_regs_ctrl.sv
module audio_regs_ctrl
  import audio_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output regStrobe_t        strb
);
  always_comb begin
    strb        = '0;
    strb.rdEn   = regRdEn;
    strb.rdSel  = RD_NONE;
    if (regAddr == ADDR_W'(OFS_GIE)) begin
      strb.wrGie = regWrEn;
      strb.rdSel = RD_GIE;
    end else if (regAddr == ADDR_W'(OFS_STS)) begin
      strb.wrSts = regWrEn;
      strb.rdSel = RD_STS;
    end else if (regAddr == ADDR_W'(OFS_IEN)) begin
      strb.wrIen = regWrEn;
      strb.rdSel = RD_IEN;
    end else if (regAddr == ADDR_W'(OFS_CTRL)) begin
      strb.wrCtrl = regWrEn;
      strb.rdSel  = RD_CTRL;
    end else if (regAddr == ADDR_W'(OFS_KEY)) begin
      strb.keyHit = regWrEn && (regWrData == RESET_KEY);
    end else if (regAddr == ADDR_W'(OFS_CHST)) begin
      strb.rdSel = RD_CHST;
    end else if (regAddr == ADDR_W'(OFS_USER)) begin
      strb.rdSel = RD_USER;
    end
  end
endmodule

// File: rtl/audio_regs_data.sv
module audio_regs_data
  import audio_regs_pkg::*;
#(
  parameter int NUM_EVT = 8,
  parameter int CFG_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  logic [NUM_EVT-1:0]  wrEvtBits,
  input  logic [CFG_W+1:0]    wrCtrlBits,
  input  logic                wrGieBit,
  input  logic [NUM_EVT-1:0]  evtIn,
  input  logic [DATA_W-1:0]   chanStatusIn,
  input  logic [DATA_W-1:0]   userDataIn,
  output logic [DATA_W-1:0]   rdData,
  output logic                coreEn,
  output logic [CFG_W-1:0]    clkCfg,
  output logic                fifoFlush,
  output logic                softRst,
  output logic                irqOut,
  output logic                gieQ,
  output logic [NUM_EVT-1:0]  stsQ,
  output logic [NUM_EVT-1:0]  ienQ
);
  localparam int CFG_LSB = 2;
  localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

  logic [DATA_W-1:0]  rdMux;
  logic [NUM_EVT-1:0] clrMask;

  assign clrMask = strb.wrSts ? wrEvtBits : '0;
  assign irqOut  = gieQ & (|(stsQ & ienQ));

  always_comb begin
    unique case (strb.rdSel)
      RD_GIE:  rdMux = {gieQ, {(DATA_W-1){1'b0}}};
      RD_STS:  rdMux = DATA_W'(stsQ);
      RD_IEN:  rdMux = DATA_W'(ienQ);
      RD_CTRL: rdMux = DATA_W'({clkCfg, 1'b0, coreEn});
      RD_CHST: rdMux = chanStatusIn;
      RD_USER: rdMux = userDataIn;
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreEn    <= 1'b0;
      clkCfg    <= '0;
      fifoFlush <= 1'b0;
      softRst   <= 1'b0;
      gieQ      <= 1'b0;
      stsQ      <= '0;
      ienQ      <= '0;
      rdData    <= '0;
    end else begin
      softRst   <= strb.keyHit;
      fifoFlush <= strb.wrCtrl && wrCtrlBits[1];
      rdData    <= strb.rdEn ? rdMux : '0;
      if (softRst) begin
        coreEn <= 1'b0;
        clkCfg <= '0;
        gieQ   <= 1'b0;
        stsQ   <= '0;
        ienQ   <= '0;
      end else begin
        if (strb.wrCtrl) begin
          coreEn <= wrCtrlBits[0];
          clkCfg <= wrCtrlBits[CFG_MSB:CFG_LSB];
        end
        if (strb.wrIen) ienQ <= wrEvtBits;
        if (strb.wrGie) gieQ <= wrGieBit;
        // new events override a clear in the same cycle
        stsQ <= (stsQ & ~clrMask) | evtIn;
      end
    end
  end
endmodule

// File: rtl/audio_ctrl_regs.sv
module audio_ctrl_regs
  import audio_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_EVT = 8,
  parameter int CFG_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [DATA_W-1:0]  chanStatusIn,
  input  logic [DATA_W-1:0]  userDataIn,
  output logic               coreEn,
  output logic [CFG_W-1:0]   clkCfg,
  output logic               fifoFlush,
  output logic               softRstOut,
  output logic               irqOut
);
  regStrobe_t         strb;
  logic               gieQ;
  logic [NUM_EVT-1:0] stsQ;
  logic [NUM_EVT-1:0] ienQ;

  audio_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdEn   (regRdEn),
    .strb      (strb)
  );

  audio_regs_data #(.NUM_EVT(NUM_EVT), .CFG_W(CFG_W)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrEvtBits    (regWrData[NUM_EVT-1:0]),
    .wrCtrlBits   (regWrData[CFG_W+1:0]),
    .wrGieBit     (regWrData[DATA_W-1]),
    .evtIn        (evtIn),
    .chanStatusIn (chanStatusIn),
    .userDataIn   (userDataIn),
    .rdData       (regRdData),
    .coreEn       (coreEn),
    .clkCfg       (clkCfg),
    .fifoFlush    (fifoFlush),
    .softRst      (softRstOut),
    .irqOut       (irqOut),
    .gieQ         (gieQ),
    .stsQ         (stsQ),
    .ienQ         (ienQ)
  );
endmodule

// File: rtl/audio_ctrl_regs_chk.sv
module audio_ctrl_regs_chk
  import audio_regs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_EVT = 8,
  parameter int CFG_W   = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [ADDR_W-1:0]  regAddr,
  input logic               regWrEn,
  input logic [DATA_W-1:0]  regWrData,
  input logic [NUM_EVT-1:0] evtIn,
  input logic               coreEn,
  input logic [CFG_W-1:0]   clkCfg,
  input logic               fifoFlush,
  input logic               softRstOut,
  input logic               irqOut,
  input logic               gieQ,
  input logic [NUM_EVT-1:0] stsQ,
  input logic [NUM_EVT-1:0] ienQ
);
  logic ctrlWrFlush, keyWr, stsWr;
  assign ctrlWrFlush = regWrEn && (regAddr == ADDR_W'(OFS_CTRL)) && regWrData[1];
  assign keyWr       = regWrEn && (regAddr == ADDR_W'(OFS_KEY)) && (regWrData == RESET_KEY);
  assign stsWr       = regWrEn && (regAddr == ADDR_W'(OFS_STS));

  assert_flush_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> $past(ctrlWrFlush));

  assert_key_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    softRstOut |-> $past(keyWr));

  assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    softRstOut |=> (!coreEn && clkCfg == '0 && !gieQ && stsQ == '0 && ienQ == '0));

  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gieQ |-> !irqOut);

  assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((|evtIn) && !softRstOut) |=> ((stsQ & $past(evtIn)) == $past(evtIn)));

  assert_sts_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!stsWr && !softRstOut) |=> ((stsQ & $past(stsQ)) == $past(stsQ)));
endmodule

bind audio_ctrl_regs audio_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .CFG_W(CFG_W)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
  .regWrData(regWrData), .evtIn(evtIn), .coreEn(coreEn), .clkCfg(clkCfg),
  .fifoFlush(fifoFlush), .softRstOut(softRstOut), .irqOut(irqOut),
  .gieQ(gieQ), .stsQ(stsQ), .ienQ(ienQ)
);

// File: tb/test_audio_ctrl_regs.sv
module test_audio_ctrl_regs;
  localparam logic [31:0] CHST = 32'hCAFE_0001;
  localparam logic [31:0] USER = 32'h5A5A_0F0F;
  localparam int NVEC = 17;
  // {isWrite, req, addr, data, expected}
  localparam logic [76:0] VECS [NVEC] = '{
    {1'b1, 4'd2,  8'h44, 32'h0000_0015, 32'h0},           // R2 coreEn=1, cfg=5
    {1'b0, 4'd2,  8'h44, 32'h0,         32'h0000_0015},   // R2
    {1'b1, 4'd3,  8'h44, 32'h0000_002B, 32'h0},           // R3 flush bit set
    {1'b0, 4'd3,  8'h44, 32'h0,         32'h0000_0029},   // R3 flush reads 0
    {1'b1, 4'd6,  8'h28, 32'hFFFF_FFFF, 32'h0},           // R6
    {1'b0, 4'd6,  8'h28, 32'h0,         32'h0000_00FF},   // R6
    {1'b1, 4'd7,  8'h1C, 32'hFFFF_FFFF, 32'h0},           // R7
    {1'b0, 4'd7,  8'h1C, 32'h0,         32'h8000_0000},   // R7
    {1'b1, 4'd9,  8'h4C, 32'h1234_5678, 32'h0},           // R9 write ignored
    {1'b0, 4'd9,  8'h4C, 32'h0,         CHST},            // R9
    {1'b1, 4'd9,  8'h64, 32'h0,         32'h0},           // R9
    {1'b0, 4'd9,  8'h64, 32'h0,         USER},            // R9
    {1'b0, 4'd8,  8'h40, 32'h0,         32'h0},           // R8 key reads 0
    {1'b0, 4'd10, 8'h00, 32'h0,         32'h0},           // R10
    {1'b0, 4'd10, 8'h45, 32'h0,         32'h0},           // R10 misaligned
    {1'b0, 4'd10, 8'hFC, 32'h0,         32'h0},           // R10
    {1'b0, 4'd4,  8'h20, 32'h0,         32'h0}            // R4 no events yet
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdEn = 1'b0;
  logic [31:0] regRdData;
  logic [7:0]  evtIn = '0;
  logic        coreEn, fifoFlush, softRstOut, irqOut;
  logic [3:0]  clkCfg;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_ctrl_regs i_audio_ctrl_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
    .evtIn(evtIn), .chanStatusIn(CHST), .userDataIn(USER),
    .coreEn(coreEn), .clkCfg(clkCfg), .fifoFlush(fifoFlush),
    .softRstOut(softRstOut), .irqOut(irqOut)
  );

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    d = regRdData;
    regRdEn = 1'b0;
  endtask

  task automatic pulseEvt(input logic [7:0] e);
    evtIn = e;
    @(negedge clk);
    evtIn = '0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(1, {27'b0, coreEn, clkCfg}, 32'h0);
    check(1, {29'b0, fifoFlush, softRstOut, irqOut}, 32'h0);
    rd(8'h44, v); check(1, v, 32'h0);
    rd(8'h20, v); check(1, v, 32'h0);
    rd(8'h28, v); check(1, v, 32'h0);
    rd(8'h1C, v); check(1, v, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i][76]) wr(VECS[i][71:64], VECS[i][63:32]);
      else begin
        rd(VECS[i][71:64], v);
        check(int'(VECS[i][75:72]), v, VECS[i][31:0]);
      end
    end

    // R2 output pins
    wr(8'h44, 32'h0000_0015);
    check(2, {27'b0, coreEn, clkCfg}, {27'b0, 1'b1, 4'd5});
    // R3 flush pulse lasts one cycle
    wr(8'h44, 32'h0000_0017);
    check(3, {31'b0, fifoFlush}, 32'h1);
    @(negedge clk);
    check(3, {31'b0, fifoFlush}, 32'h0);

    // R7 no status yet, no interrupt
    check(7, {31'b0, irqOut}, 32'h0);
    // R4 channel-status event on bit 5
    pulseEvt(8'h20);
    check(7, {31'b0, irqOut}, 32'h1);
    rd(8'h20, v); check(4, v, 32'h20);
    wr(8'h1C, 32'h0);
    check(7, {31'b0, irqOut}, 32'h0);
    wr(8'h1C, 32'h8000_0000);
    check(7, {31'b0, irqOut}, 32'h1);
    wr(8'h28, 32'h0);
    check(7, {31'b0, irqOut}, 32'h0);
    wr(8'h28, 32'hFF);
    wr(8'h20, 32'h0);
    rd(8'h20, v); check(4, v, 32'h20);
    wr(8'h20, 32'hFFFF_FF20);
    rd(8'h20, v); check(4, v, 32'h0);
    check(7, {31'b0, irqOut}, 32'h0);

    // R5 event coinciding with clear
    pulseEvt(8'h08);
    evtIn = 8'h08;
    wr(8'h20, 32'h08);
    evtIn = '0;
    rd(8'h20, v); check(5, v, 32'h08);

    // R11 read data returns to zero without a read
    rd(8'h44, v); check(11, v, 32'h15);
    @(negedge clk);
    check(11, regRdData, 32'h0);

    // R8 wrong key ignored
    wr(8'h40, 32'h0000_0005);
    check(8, {31'b0, softRstOut}, 32'h0);
    @(negedge clk);
    rd(8'h44, v); check(8, v, 32'h15);
    wr(8'h40, 32'h0000_010A);
    check(8, {31'b0, softRstOut}, 32'h0);
    @(negedge clk);
    // R8 correct key
    wr(8'h40, 32'h0000_000A);
    check(8, {31'b0, softRstOut}, 32'h1);
    @(negedge clk);
    check(8, {31'b0, softRstOut}, 32'h0);
    check(8, {27'b0, coreEn, clkCfg}, 32'h0);
    check(8, {31'b0, irqOut}, 32'h0);
    rd(8'h44, v); check(8, v, 32'h0);
    rd(8'h28, v); check(8, v, 32'h0);
    rd(8'h1C, v); check(8, v, 32'h0);
    rd(8'h20, v); check(8, v, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule